// File: doc/BRIEF.md
# Sector Page Load Buffer

This block collects the bytes of one flash sector before that sector is reprogrammed. Once the upstream command decoder has recognised a program-enable sequence, it pulses `progEnable`. The buffer then accepts single-cycle byte loads. Each load carries a full byte address, which splits into a sector number and an offset inside the sector. Bytes may arrive in any order, and the same offset may be written more than once. The page image shows every byte that was never loaded as the erased value FFh.

The first accepted load fixes the sector for the phase. A later load that names a different sector is dropped and sets a sticky error flag. The load phase has no fixed byte count and no closing command. It ends when no accepted load arrives within a window of `WINDOW_US` microseconds, which is converted to clock cycles from `CLK_HZ`. When the window expires, the block emits a one-cycle `progStart` pulse to the program timer. It holds the sector number and the 128-byte image stable until the next enable.

Top module: `page_load_buffer`

## Requirements
- R1: A `progEnable` pulse while no load phase is open opens a phase: `loadActive` is high from the next cycle, `secErr` is cleared, and every byte of `pageImage` reads FFh.
- R2: For a load, `wrAddr[6:0]` is the byte offset k and `wrAddr[16:7]` is the sector number; byte k appears on `pageImage[8k+7:8k]`.
- R3: Loads may come in any offset order, and a second load to the same offset replaces the earlier byte.
- R4: Any offset not loaded during the phase reads FFh in `pageImage`.
- R5: The first load of a phase sets `pageSector` to its sector number.
- R6: A later load whose sector differs from `pageSector` does not change the image or restart the window, and it sets `secErr`.
- R7: `progStart` is a single-cycle pulse that rises exactly TIMEOUT_CYC = CLK_HZ/1e6*WINDOW_US clock edges after the last accepted load, and `loadActive` falls on that same edge.
- R8: An accepted load that arrives inside the window restarts the window and keeps the phase open.
- R9: Before the first load of a phase no timeout runs; the phase stays open without limit.
- R10: Outside a load phase, loads are ignored, and `pageImage` and `pageSector` stay unchanged until the next `progEnable`.
- R11: `secErr` stays set until the next phase is opened, including after `progStart`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| progEnable | input | 1 | One-cycle pulse: program-enable sequence recognised |
| wrStrobe | input | 1 | One-cycle byte load |
| wrAddr | input | 17 | Byte address of the load (sector and offset) |
| wrData | input | 8 | Byte value of the load |
| loadActive | output | 1 | A load phase is open |
| pageSector | output | 10 | Sector number captured in this phase |
| pageImage | output | 1024 | Page image; byte k on bits 8k+7..8k |
| progStart | output | 1 | One-cycle pulse to start programming |
| secErr | output | 1 | Sticky flag: a load named a different sector |

## Verification
The first test writes a short burst out of offset order and rewrites one offset. It shows whether placement, overwrite and FFh filling are all correct. The second test leaves a long idle gap before the first byte, then sends a load to another sector. This separates a timer that runs before the first load from one that waits, and it shows whether a dropped load extends the window. Other tests space accepted loads just inside the window and send writes after the phase has closed. These test whether the restart and the hold behaviour work. A scoreboard compares each `progStart` against the expected sector and image, and against the edge count since the last good load.

// File: rtl/page_load_pkg.sv
package page_load_pkg;
  typedef struct packed {
    logic clearAll;
    logic writeByte;
  } ctlStrobes_t;
endpackage

// File: rtl/page_load_ctrl.sv
module page_load_ctrl
  import page_load_pkg::*;
#(
  parameter int SECT_W      = 10,
  parameter int TIMEOUT_CYC = 7500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              progEnable,
  input  logic              wrStrobe,
  input  logic [SECT_W-1:0] wrSector,
  output ctlStrobes_t       strobes,
  output logic [SECT_W-1:0] sectorQ,
  output logic              loadActive,
  output logic              progStart,
  output logic              secErr
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_LOADING} phase_t;
  phase_t state;
  logic [CNT_W-1:0] idleCnt;
  logic accept, mismatch;

  assign accept   = wrStrobe && ((state == ST_ARMED) ||
                    (state == ST_LOADING && wrSector == sectorQ));
  assign mismatch = wrStrobe && state == ST_LOADING && wrSector != sectorQ;

  assign strobes.clearAll  = (state == ST_IDLE) && progEnable;
  assign strobes.writeByte = accept;
  assign loadActive        = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      sectorQ   <= '0;
      idleCnt   <= '0;
      progStart <= 1'b0;
      secErr    <= 1'b0;
    end else begin
      progStart <= 1'b0;
      case (state)
        ST_IDLE: if (progEnable) begin
          state   <= ST_ARMED;
          secErr  <= 1'b0;
          idleCnt <= '0;
        end
        ST_ARMED: if (wrStrobe) begin
          sectorQ <= wrSector;
          idleCnt <= '0;
          state   <= ST_LOADING;
        end
        ST_LOADING: begin
          if (mismatch) secErr <= 1'b1;
          if (accept) begin
            idleCnt <= '0;
          end else if (idleCnt == CNT_W'(TIMEOUT_CYC - 1)) begin
            idleCnt   <= '0;
            progStart <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            idleCnt <= idleCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/page_load_data.sv
module page_load_data
  import page_load_pkg::*;
#(
  parameter int OFFS_W = 7
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctlStrobes_t                strobes,
  input  logic [OFFS_W-1:0]          wrOffset,
  input  logic [7:0]                 wrData,
  output logic [8*(1<<OFFS_W)-1:0]   pageImage
);
  localparam int PAGE_BYTES = 1 << OFFS_W;

  logic [7:0]            byteMem [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] loaded;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loaded <= '0;
    end else if (strobes.clearAll) begin
      loaded <= '0;
    end else if (strobes.writeByte) begin
      loaded[wrOffset] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.writeByte) byteMem[wrOffset] <= wrData;
  end

  for (genvar k = 0; k < PAGE_BYTES; k++) begin : g_byte
    assign pageImage[8*k +: 8] = loaded[k] ? byteMem[k] : 8'hFF;
  end
endmodule

// File: rtl/page_load_buffer.sv
module page_load_buffer
  import page_load_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int WINDOW_US = 150,
  parameter int ADDR_W    = 17,
  parameter int OFFS_W    = 7
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              progEnable,
  input  logic                              wrStrobe,
  input  logic [ADDR_W-1:0]                 wrAddr,
  input  logic [7:0]                        wrData,
  output logic                              loadActive,
  output logic [ADDR_W-OFFS_W-1:0]          pageSector,
  output logic [8*(1<<OFFS_W)-1:0]          pageImage,
  output logic                              progStart,
  output logic                              secErr
);
  localparam int SECT_W      = ADDR_W - OFFS_W;
  localparam int TIMEOUT_CYC = (CLK_HZ / 1_000_000) * WINDOW_US;

  ctlStrobes_t strobes;

  page_load_ctrl #(.SECT_W(SECT_W), .TIMEOUT_CYC(TIMEOUT_CYC)) ctrl_i (
    .clk, .rstN, .progEnable, .wrStrobe,
    .wrSector(wrAddr[ADDR_W-1:OFFS_W]),
    .strobes, .sectorQ(pageSector), .loadActive, .progStart, .secErr
  );

  page_load_data #(.OFFS_W(OFFS_W)) data_i (
    .clk, .rstN, .strobes,
    .wrOffset(wrAddr[OFFS_W-1:0]), .wrData, .pageImage
  );
endmodule

// File: rtl/page_load_checker.sv
module page_load_checker #(
  parameter int SECT_W  = 10,
  parameter int IMG_W   = 1024
) (
  input logic              clk,
  input logic              rstN,
  input logic              progEnable,
  input logic              wrStrobe,
  input logic              loadActive,
  input logic [SECT_W-1:0] pageSector,
  input logic [IMG_W-1:0]  pageImage,
  input logic              progStart,
  input logic              secErr
);
  p_open_clears_r1: assert property (@(posedge clk) disable iff (!rstN)
    (progEnable && !loadActive) |=> (loadActive && !secErr && &pageImage));

  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    progStart |=> !progStart);

  p_close_with_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(loadActive) |-> progStart);

  p_err_needs_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(secErr) |-> $past(wrStrobe));

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    (secErr && !progEnable) |=> secErr);

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!loadActive && !progEnable) |=> ($stable(pageImage) && $stable(pageSector)));
endmodule

bind page_load_buffer page_load_checker #(
  .SECT_W(ADDR_W - OFFS_W), .IMG_W(8 * (1 << OFFS_W))
) checker_i (
  .clk, .rstN, .progEnable, .wrStrobe, .loadActive,
  .pageSector, .pageImage, .progStart, .secErr
);

// File: tb/page_load_buffer_tb_top.sv
module page_load_buffer_tb_top;
  localparam int TMO = 50 * 150;

  typedef struct {
    logic [9:0]    sector;
    logic [1023:0] image;
  } expItem_t;

  logic clk = 0;
  logic rstN = 0;
  logic progEnable = 0;
  logic wrStrobe = 0;
  logic [16:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic loadActive, progStart, secErr;
  logic [9:0] pageSector;
  logic [1023:0] pageImage;

  int nChecks = 0, nFail = 0, cyc = 0, lastGood = 0;
  expItem_t expQ[$];
  logic [1023:0] expImg;
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  page_load_buffer dut_i (
    .clk, .rstN, .progEnable, .wrStrobe, .wrAddr, .wrData,
    .loadActive, .pageSector, .pageImage, .progStart, .secErr
  );

  task automatic chk(input bit ok, input string msg);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic openPhase();
    @(negedge clk) progEnable = 1;
    @(negedge clk) progEnable = 0;
    expImg = '1;
  endtask

  task automatic load(input logic [9:0] sec, input logic [6:0] off,
                      input logic [7:0] d, input bit good);
    @(negedge clk);
    wrStrobe = 1; wrAddr = {sec, off}; wrData = d;
    @(negedge clk);
    wrStrobe = 0;
    if (good) begin
      lastGood = cyc;
      expImg[8*off +: 8] = d;
    end
  endtask

  task automatic waitEnd();
    while (loadActive) @(negedge clk);
    @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && progStart) begin
      if (expQ.size() == 0) begin
        chk(0, "R7 unexpected progStart (actual 1 expected 0)");
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        chk(pageSector == e.sector,
            $sformatf("R5 sector actual %0h expected %0h", pageSector, e.sector));
        chk(pageImage == e.image,
            $sformatf("R2/R4 image actual %h expected %h", pageImage, e.image));
        chk(cyc - lastGood == TMO,
            $sformatf("R7 start delay actual %0d expected %0d", cyc - lastGood, TMO));
        chk(!loadActive, $sformatf("R7 loadActive actual %0b expected 0", loadActive));
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nFail++; nChecks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic [1023:0] held;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(!loadActive && !progStart && !secErr && &pageImage,
        $sformatf("R1 reset state actual %0b%0b%0b expected 000", loadActive, progStart, secErr));

    // A: out of order, overwrite
    openPhase();
    chk(loadActive && &pageImage, $sformatf("R1 open actual %0b expected 1", loadActive));
    load(10'h155, 7'd5, 8'h11, 1);
    chk(pageSector == 10'h155, $sformatf("R5 sector actual %0h expected 155", pageSector));
    load(10'h155, 7'd127, 8'h7E, 1);
    load(10'h155, 7'd0, 8'h00, 1);
    load(10'h155, 7'd5, 8'hA5, 1);
    chk(pageImage[8*5 +: 8] == 8'hA5, $sformatf("R3 overwrite actual %h expected a5", pageImage[8*5 +: 8]));
    chk(pageImage[8*6 +: 8] == 8'hFF, $sformatf("R4 unloaded actual %h expected ff", pageImage[8*6 +: 8]));
    expQ.push_back('{10'h155, expImg});
    waitEnd();
    chk(expQ.size() == 0, $sformatf("R7 pending items actual %0d expected 0", expQ.size()));

    // R10: loads while closed are ignored
    held = pageImage;
    load(10'h155, 7'd9, 8'h33, 0);
    repeat (20) @(negedge clk);
    chk(pageImage == held && pageSector == 10'h155 && !loadActive,
        "R10 image changed by load outside phase");

    // B: no timeout before first byte, sector mismatch
    openPhase();
    chk(&pageImage && !secErr, "R1 reopen did not clear image");
    repeat (20000) @(negedge clk);
    chk(loadActive, $sformatf("R9 phase closed early actual %0b expected 1", loadActive));
    load(10'h003, 7'd64, 8'h5A, 1);
    repeat (100) @(negedge clk);
    load(10'h004, 7'd1, 8'hC3, 0);
    chk(secErr, $sformatf("R6 secErr actual %0b expected 1", secErr));
    chk(pageImage[8*1 +: 8] == 8'hFF, $sformatf("R6 dropped byte actual %h expected ff", pageImage[8*1 +: 8]));
    expQ.push_back('{10'h003, expImg});
    waitEnd();
    chk(secErr, $sformatf("R11 secErr after start actual %0b expected 1", secErr));

    // C: loads spaced inside the window
    openPhase();
    chk(!secErr, $sformatf("R11 secErr after reopen actual %0b expected 0", secErr));
    load(10'h3FF, 7'd10, 8'h01, 1);
    for (int i = 0; i < 3; i++) begin
      repeat (7400) @(negedge clk);
      chk(loadActive, $sformatf("R8 phase closed inside window actual %0b expected 1", loadActive));
      load(10'h3FF, 7'(20 + i), 8'(8'h40 + i), 1);
    end
    expQ.push_back('{10'h3FF, expImg});
    waitEnd();
    chk(expQ.size() == 0 && !secErr, "R8 final page not delivered");

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule